// File: doc/BRIEF.md
# Data Queue with Burst Request Thresholds

This block is a first-in first-out word queue that sits between a host bus and the engine that shifts data on the card data lines. It serves one direction at a time. In receive mode the line engine fills the queue and the bus drains it. In transmit mode the bus fills it and the line engine drains it. A single direction input steers the push and pop strobes of the two sides onto one store. Strobes from the side that does not own that role are ignored.

Two level-sensitive request outputs tell a DMA channel or a polling loop when a burst may run. The receive request is raised when a full burst is waiting. The transmit request is raised when room for a full burst exists. In either case the burst is a fixed number of single-word accesses, and a shorter last burst is legal. A status vector reports empty, full and almost-full at fixed bit positions. Two sticky flags record a push into a full queue and a pop from an empty one. Reset or a flush pulse empties the queue in one cycle.

Top module: `sdx_data_fifo`

## Requirements
- R1: A cycle with `rst` or `flush` high leaves the queue empty at the next edge and clears both sticky flags. This holds even when a push is strobed in the same cycle.
- R2: Words leave in the order they were accepted. The popping side sees the oldest word on its read-data port, combinationally, in the cycle it strobes pop.
- R3: With `dir_tx` = 0 (receive), only `line_push` and `bus_pop` act. With `dir_tx` = 1 (transmit), only `bus_push` and `line_pop` act. The other two strobes have no effect, and the read-data port of the side that is not popping reads zero.
- R4: `req_word` bit 5 (receive request) is 1 exactly when the mode is receive and the queue holds at least THRESH (8) words.
- R5: `req_word` bit 6 (transmit request) is 1 exactly when the mode is transmit and the queue holds fewer than THRESH (8) words. All other `req_word` bits are 0.
- R6: `status_word` bit 6 is 1 when the queue holds 0 words. Bit 7 is 1 when it holds DEPTH (16) words. Bit 10 is 1 when it holds at least DEPTH-1 (15) words. All other bits are 0.
- R7: A push into a full queue is dropped without changing contents or level, and sets `ovf_sticky`. The flag stays set until reset or flush.
- R8: A pop from an empty queue changes nothing, reads zero data, and sets `udf_sticky`. The flag stays set until reset or flush. Popping an extra word left at the end of a read is therefore harmless.
- R9: A push and a pop in the same cycle both take effect and leave the level unchanged, with two exceptions. When the queue is empty, only the push is taken. When it is full, only the pop is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous queue clear |
| dir_tx | input | 1 | 0 = receive mode, 1 = transmit mode |
| line_push | input | 1 | Line-engine push strobe (receive mode) |
| line_wdata | input | WIDTH | Line-engine write word |
| line_pop | input | 1 | Line-engine pop strobe (transmit mode) |
| line_rdata | output | WIDTH | Oldest word in transmit mode, else zero |
| bus_push | input | 1 | Bus push strobe (transmit mode) |
| bus_wdata | input | WIDTH | Bus write word |
| bus_pop | input | 1 | Bus pop strobe (receive mode) |
| bus_rdata | output | WIDTH | Oldest word in receive mode, else zero |
| status_word | output | 16 | Bit 6 empty, bit 7 full, bit 10 almost full |
| req_word | output | 8 | Bit 5 receive request, bit 6 transmit request |
| ovf_sticky | output | 1 | Push-while-full seen since last clear |
| udf_sticky | output | 1 | Pop-while-empty seen since last clear |

## Verification
The queue is filled one word at a time in receive mode. The request bit is checked just below the threshold and at it, and the status bits at the almost-full and full levels. This separates an off-by-one threshold from a wrong comparison sense. Strobes on the non-owning side are then applied in each mode, to catch steering that honours the wrong side. Simultaneous push and pop is tried at a middle level, at empty and at full, which separates the three acceptance cases. A flush that coincides with a push shows that clearing takes priority.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

    localparam int ST_EMPTY_BIT = 6;
    localparam int ST_FULL_BIT  = 7;
    localparam int ST_AFULL_BIT = 10;
    localparam int RQ_RX_BIT    = 5;
    localparam int RQ_TX_BIT    = 6;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    typedef struct packed {
        logic push;
        logic pop;
    } xfer_t;

    function automatic logic [15:0] make_status(input logic e, input logic f, input logic af);
        logic [15:0] s;
        s = '0;
        s[ST_EMPTY_BIT] = e;
        s[ST_FULL_BIT]  = f;
        s[ST_AFULL_BIT] = af;
        return s;
    endfunction

    function automatic logic [7:0] make_req(input logic rx, input logic tx);
        logic [7:0] r;
        r = '0;
        r[RQ_RX_BIT] = rx;
        r[RQ_TX_BIT] = tx;
        return r;
    endfunction

endpackage

// File: rtl/dfifo_steer.sv
module dfifo_steer
    import dfifo_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  dir_e             dir,
    input  logic             line_push,
    input  logic [WIDTH-1:0] line_wdata,
    input  logic             line_pop,
    input  logic             bus_push,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_pop,
    input  logic [WIDTH-1:0] head,
    input  logic             empty,
    output xfer_t            xr,
    output logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] line_rdata,
    output logic [WIDTH-1:0] bus_rdata
);
    logic [WIDTH-1:0] shown;

    assign shown = empty ? '0 : head;

    always_comb begin
        if (dir == DIR_TX) begin
            xr.push    = bus_push;
            xr.pop     = line_pop;
            wdata      = bus_wdata;
            line_rdata = shown;
            bus_rdata  = '0;
        end else begin
            xr.push    = line_push;
            xr.pop     = bus_pop;
            wdata      = line_wdata;
            line_rdata = '0;
            bus_rdata  = shown;
        end
    end
endmodule

// File: rtl/dfifo_level.sv
module dfifo_level #(
    parameter int DEPTH  = 16,
    parameter int THRESH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic push_req,
    input  logic pop_req,
    output logic push_acc,
    output logic pop_acc,
    output logic empty,
    output logic full,
    output logic afull,
    output logic at_thresh,
    output logic ovf,
    output logic udf
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_LVL  = CW'(DEPTH);
    localparam logic [CW-1:0] AFULL_LVL = CW'(DEPTH - 1);
    localparam logic [CW-1:0] TH_LVL    = CW'(THRESH);

    logic [CW-1:0] count_q;

    assign empty     = (count_q == '0);
    assign full      = (count_q == FULL_LVL);
    assign afull     = (count_q >= AFULL_LVL);
    assign at_thresh = (count_q >= TH_LVL);
    assign push_acc  = push_req && !full;
    assign pop_acc   = pop_req && !empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            count_q <= '0;
            ovf     <= 1'b0;
            udf     <= 1'b0;
        end else begin
            case ({push_acc, pop_acc})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (push_req && full)
                ovf <= 1'b1;
            if (pop_req && empty)
                udf <= 1'b1;
        end
    end
endmodule

// File: rtl/dfifo_store.sv
module dfifo_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] head
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [DEPTH-1:0][WIDTH-1:0] slots;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == AW'(i))
                slot_q <= wr_data;
        end
        assign slots[i] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en)
                wr_ptr <= wr_ptr + 1'b1;
            if (rd_en)
                rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign head = slots[rd_ptr];
endmodule

// File: rtl/sdx_data_fifo.sv
module sdx_data_fifo
    import dfifo_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int DEPTH  = 16,
    parameter int THRESH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             dir_tx,
    input  logic             line_push,
    input  logic [WIDTH-1:0] line_wdata,
    input  logic             line_pop,
    output logic [WIDTH-1:0] line_rdata,
    input  logic             bus_push,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_pop,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [15:0]      status_word,
    output logic [7:0]       req_word,
    output logic             ovf_sticky,
    output logic             udf_sticky
);
    dir_e             dir;
    xfer_t            xr;
    logic [WIDTH-1:0] wdata, head;
    logic             push_acc, pop_acc, empty, full, afull, at_thresh;

    assign dir = dir_e'(dir_tx);

    dfifo_steer #(.WIDTH(WIDTH)) u_steer (
        .dir        (dir),
        .line_push  (line_push),
        .line_wdata (line_wdata),
        .line_pop   (line_pop),
        .bus_push   (bus_push),
        .bus_wdata  (bus_wdata),
        .bus_pop    (bus_pop),
        .head       (head),
        .empty      (empty),
        .xr         (xr),
        .wdata      (wdata),
        .line_rdata (line_rdata),
        .bus_rdata  (bus_rdata)
    );

    dfifo_level #(.DEPTH(DEPTH), .THRESH(THRESH)) u_level (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push_req  (xr.push),
        .pop_req   (xr.pop),
        .push_acc  (push_acc),
        .pop_acc   (pop_acc),
        .empty     (empty),
        .full      (full),
        .afull     (afull),
        .at_thresh (at_thresh),
        .ovf       (ovf_sticky),
        .udf       (udf_sticky)
    );

    dfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (push_acc),
        .wr_data (wdata),
        .rd_en   (pop_acc),
        .head    (head)
    );

    assign status_word = make_status(empty, full, afull);
    assign req_word    = make_req(at_thresh && dir == DIR_RX,
                                  !at_thresh && dir == DIR_TX);
endmodule

// File: rtl/dfifo_checker.sv
module dfifo_checker (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        dir_tx,
    input logic        line_push,
    input logic        line_pop,
    input logic        bus_push,
    input logic        bus_pop,
    input logic [15:0] status_word,
    input logic [7:0]  req_word,
    input logic        ovf_sticky,
    input logic        udf_sticky
);
    logic push_eff, pop_eff;
    assign push_eff = dir_tx ? bus_push : line_push;
    assign pop_eff  = dir_tx ? line_pop : bus_pop;

    // R1
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (status_word[6] && !ovf_sticky && !udf_sticky));

    // R7
    full_push_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (status_word[7] && push_eff && !pop_eff && !flush) |=> (status_word[7] && ovf_sticky));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_sticky && !flush) |=> ovf_sticky);

    // R8
    empty_pop_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (status_word[6] && pop_eff && !push_eff && !flush) |=> (status_word[6] && udf_sticky));

    // R8
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (udf_sticky && !flush) |=> udf_sticky);

    // R4
    rx_req_mode_chk: assert property (@(posedge clk) disable iff (rst)
        req_word[5] |-> (!dir_tx && !status_word[6]));

    // R5
    tx_req_mode_chk: assert property (@(posedge clk) disable iff (rst)
        req_word[6] |-> (dir_tx && !status_word[7]));

    // R6
    full_afull_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[7] |-> (status_word[10] && !status_word[6]));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!push_eff && !pop_eff && !flush) |=> $stable(status_word));
endmodule

bind sdx_data_fifo dfifo_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .dir_tx      (dir_tx),
    .line_push   (line_push),
    .line_pop    (line_pop),
    .bus_push    (bus_push),
    .bus_pop     (bus_pop),
    .status_word (status_word),
    .req_word    (req_word),
    .ovf_sticky  (ovf_sticky),
    .udf_sticky  (udf_sticky)
);

// File: tb/sim_sdx_data_fifo.sv
`timescale 1ns/1ps
module sim_sdx_data_fifo;
    localparam logic [15:0] S_EMPTY = 16'h0040;
    localparam logic [15:0] S_MID   = 16'h0000;
    localparam logic [15:0] S_AFULL = 16'h0400;
    localparam logic [15:0] S_FULL  = 16'h0480;
    localparam logic [7:0]  Q_RX    = 8'h20;
    localparam logic [7:0]  Q_TX    = 8'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0, dir_tx = 1'b0;
    logic line_push = 1'b0, line_pop = 1'b0, bus_push = 1'b0, bus_pop = 1'b0;
    logic [31:0] line_wdata = '0, bus_wdata = '0, line_rdata, bus_rdata;
    logic [15:0] status_word;
    logic [7:0]  req_word;
    logic ovf_sticky, udf_sticky;

    int vecs = 0, errs = 0, mlev = 0;
    bit pop_ok_exp = 1'b0;
    logic [31:0] expq[$];

    always #2.5 clk = ~clk;

    sdx_data_fifo u0 (
        .clk(clk), .rst(rst), .flush(flush), .dir_tx(dir_tx),
        .line_push(line_push), .line_wdata(line_wdata), .line_pop(line_pop), .line_rdata(line_rdata),
        .bus_push(bus_push), .bus_wdata(bus_wdata), .bus_pop(bus_pop), .bus_rdata(bus_rdata),
        .status_word(status_word), .req_word(req_word),
        .ovf_sticky(ovf_sticky), .udf_sticky(udf_sticky)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input bit lp, input bit lq, input bit bp, input bit bq,
                        input bit fl, input logic [31:0] d);
        line_push = lp; line_pop = lq; bus_push = bp; bus_pop = bq; flush = fl;
        line_wdata = d; bus_wdata = d;
        @(posedge clk); #1;
        line_push = 0; line_pop = 0; bus_push = 0; bus_pop = 0; flush = 0;
    endtask

    // driver: models acceptance and fills the scoreboard queue
    task automatic op(input bit do_push, input bit do_pop, input logic [31:0] d);
        bit ap, aq;
        ap = do_push && (mlev < 16);
        aq = do_pop && (mlev > 0);
        pop_ok_exp = aq;
        if (ap) expq.push_back(d);
        mlev = mlev + int'(ap) - int'(aq);
        if (dir_tx) step(0, do_pop, do_push, 0, 0, d);
        else        step(do_push, 0, 0, do_pop, 0, d);
    endtask

    // monitor: compares popped words against the scoreboard
    always @(negedge clk) begin
        if (!rst && (dir_tx ? line_pop : bus_pop)) begin
            if (pop_ok_exp) check("R2 order", dir_tx ? line_rdata : bus_rdata, expq.pop_front());
            else            check("R8 empty read", dir_tx ? line_rdata : bus_rdata, 32'h0);
            check("R3 idle side rdata", dir_tx ? bus_rdata : line_rdata, 32'h0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check("R1 reset status", 32'(status_word), 32'(S_EMPTY));
        check("R6 reset status", 32'(req_word), 32'h0);
        check("R1 reset flags", {30'b0, ovf_sticky, udf_sticky}, 32'h0);

        // receive fill
        for (int i = 0; i < 7; i++) op(1, 0, 32'hA000_0000 + i);
        check("R4 below threshold", 32'(req_word), 32'h0);
        op(1, 0, 32'hA000_0007);
        check("R4 at threshold", 32'(req_word), 32'(Q_RX));
        for (int i = 8; i < 15; i++) op(1, 0, 32'hA000_0000 + i);
        check("R6 almost full", 32'(status_word), 32'(S_AFULL));
        op(1, 0, 32'hA000_000F);
        check("R6 full", 32'(status_word), 32'(S_FULL));
        check("R7 no ovf yet", 32'(ovf_sticky), 32'h0);
        op(1, 0, 32'hDEAD_BEEF);
        check("R7 ovf set", 32'(ovf_sticky), 32'h1);
        check("R7 still full", 32'(status_word), 32'(S_FULL));

        for (int i = 0; i < 16; i++) op(0, 1, '0);
        check("R6 drained", 32'(status_word), 32'(S_EMPTY));
        check("R7 ovf sticky", 32'(ovf_sticky), 32'h1);
        op(0, 1, '0);
        check("R8 udf set", 32'(udf_sticky), 32'h1);
        check("R8 still empty", 32'(status_word), 32'(S_EMPTY));

        step(0, 0, 0, 0, 1, '0);
        check("R1 flush flags", {30'b0, ovf_sticky, udf_sticky}, 32'h0);

        // wrong-side strobes in receive mode
        step(0, 0, 1, 0, 0, 32'h1111_1111);
        check("R3 bus push ignored rx", 32'(status_word), 32'(S_EMPTY));
        op(1, 0, 32'h2222_2222);
        step(0, 1, 0, 0, 0, '0);
        check("R3 line pop ignored rx", 32'(status_word), 32'(S_MID));
        op(0, 1, '0);
        check("R3 drained", 32'(status_word), 32'(S_EMPTY));

        // transmit mode
        dir_tx = 1;
        step(0, 0, 0, 0, 0, '0);
        check("R5 tx empty req", 32'(req_word), 32'(Q_TX));
        for (int i = 0; i < 7; i++) op(1, 0, 32'hB000_0000 + i);
        check("R5 tx below threshold", 32'(req_word), 32'(Q_TX));
        op(1, 0, 32'hB000_0007);
        check("R5 tx at threshold", 32'(req_word), 32'h0);
        op(1, 1, 32'hB000_0008);
        check("R9 push+pop mid keeps level", 32'(req_word), 32'h0);
        op(0, 1, '0);
        check("R5 tx back below", 32'(req_word), 32'(Q_TX));
        step(1, 0, 0, 0, 0, 32'h3333_3333);
        check("R3 line push ignored tx", 32'(req_word), 32'(Q_TX));
        for (int i = 0; i < 7; i++) op(0, 1, '0);
        check("R6 tx drained", 32'(status_word), 32'(S_EMPTY));
        op(1, 1, 32'hC000_0000);
        check("R9 empty push taken", 32'(status_word), 32'(S_MID));
        check("R9 empty pop rejected", 32'(udf_sticky), 32'h1);
        op(0, 1, '0);
        for (int i = 0; i < 16; i++) op(1, 0, 32'hD000_0000 + i);
        check("R6 tx full", 32'(status_word), 32'(S_FULL));
        op(1, 1, 32'hEEEE_EEEE);
        check("R9 full pop taken", 32'(status_word), 32'(S_AFULL));
        check("R9 full push rejected", 32'(ovf_sticky), 32'h1);

        step(0, 0, 1, 0, 1, 32'h4444_4444);
        check("R1 flush beats push", 32'(status_word), 32'(S_EMPTY));
        expq.delete();
        mlev = 0;

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule